// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one primitive bus phase at a time against an 8-bit NAND flash device. A phase can be a command latch, an address latch, a page write, a page read, an ID read or a status read. Software first loads the command byte, the address byte or the buffer-area index through a small register window. It then writes a single trigger bit to the operation register. The sequencer drives chip enable, the two latch enables and the write and read strobes. It then waits for the device's ready/busy line to show ready, and only after that sets a sticky done flag. An optional interrupt follows the done flag.

Page data moves through an on-chip staging buffer. The buffer has four 512-byte main areas and four 16-byte spare areas. Software fills or drains the buffer byte by byte through the same register window. A 2 KB page is handled as four transfers, one for each buffer area, in order. A spare-only mode limits a transfer to the 16 spare bytes of the selected area.

Host map: buffer bytes at 0x000–0x83F (main area k at k·0x200, spare area k at 0x800 + k·0x10, data in bits 7:0); operation 0xE00; configuration 0xE02; buffer select 0xE04 (bits 1:0); command byte 0xE06; address 0xE08.

Top module: `nand_seq`

## Requirements
- R1: After reset, the operation register reads 0x0000 and irq is 0. The configuration register holds 0x10, so the interrupt is masked. nf_ce_n, nf_we_n and nf_re_n are 1, and nf_cle and nf_ale are 0.
- R2: Writing 0x0001 to the operation register gives one nf_we_n pulse. During the pulse nf_cle=1, nf_ale=0 and nf_dout equals the command byte.
- R3: Writing 0x0002 gives one nf_we_n pulse. During the pulse nf_ale=1, nf_cle=0 and nf_dout equals bits 7:0 of the address register.
- R4: Writing 0x0004 sends, with both latch enables low, the 512 main bytes and then the 16 spare bytes of the area named in buffer select, each in ascending offset order.
- R5: Writing 0x0008 reads 528 bytes from the flash. The first 512 go in ascending order into the selected main area, and the last 16 go into the selected spare area.
- R6: While configuration bit 2 is 1, operations 0x0004 and 0x0008 move only the 16 spare bytes of the selected area, and the main area is left untouched.
- R7: Writing 0x0010 reads 5 bytes into offsets 0–4 of the selected main area.
- R8: Writing 0x0020 reads one byte into offset 0 of the selected main area.
- R9: Bit 15 of the operation register (done) rises only after the bus cycles end and nf_rb is high. It stays at 1 until software writes the register with bit 15 = 0.
- R10: irq equals done AND NOT configuration bit 4.
- R11: An operation write made while a phase is running is ignored. An operation write with more than one of bits 5:0 set is ignored, and done is unchanged.
- R12: Each nf_we_n and nf_re_n low pulse lasts T_LO clocks and each high gap lasts T_HI clocks. Read data is captured on the clock edge at which nf_re_n rises.
- R13: While configuration bit 7 is 1, nf_ce_n is 0 even when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 12 | Host byte address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Done interrupt |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dout | output | 8 | Data to flash |
| nf_doe | output | 1 | Data output enable |
| nf_din | input | 8 | Data from flash |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
A wrong byte counter or area index shows up at the pins within the same transfer. The pulse count or the bytes seen on nf_dout go wrong, or a read lands at the wrong host-visible buffer offset as soon as the buffer is read back. A wrong sequencer state shows up within a few clocks, either as strobes that overlap, latch enables active outside a pulse window, or done rising while the device still reports busy. A wrong done or configuration bit shows up at once on irq and in the operation register read.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ID_BYTES    = 5,
  parameter int T_LO        = 2,
  parameter int T_HI        = 2,
  parameter int RB_GAP      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic [11:0] h_addr,
  input  logic [15:0] h_wdata,
  output logic [15:0] h_rdata,
  output logic        irq,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dout,
  output logic        nf_doe,
  input  logic [7:0]  nf_din,
  input  logic        nf_rb
);
  localparam int PAGE       = MAIN_BYTES + SPARE_BYTES;
  localparam int BUF_BYTES  = 4 * PAGE;
  localparam int SPARE_BASE = 4 * MAIN_BYTES;
  localparam int AW = $clog2(BUF_BYTES);
  localparam int CW = $clog2(PAGE + 1);
  localparam int PMAX = (T_LO + T_HI > RB_GAP) ? T_LO + T_HI : RB_GAP;
  localparam int PW = $clog2(PMAX + 1);
  localparam logic [11:0] A_OPER = 12'hE00, A_CFG = 12'hE02, A_BSEL = 12'hE04,
                          A_CMD = 12'hE06, A_ADDR = 12'hE08;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_WAITRB} st_t;

  st_t st;
  logic [7:0]    mem [BUF_BYTES];
  logic [5:0]    op;
  logic          done, sp, rb_m, rb_q;
  logic [7:0]    cfg, cmd_r;
  logic [15:0]   addr_r;
  logic [1:0]    bsel, area;
  logic [CW-1:0] cnt, last, soff;
  logic [PW-1:0] ph;
  logic [AW-1:0] baddr;

  wire k_cmd = op[0], k_adr = op[1], k_din = op[2], k_dout = op[3], k_id = op[4];
  wire is_rd = k_dout | k_id | op[5];
  wire is_wr = k_cmd | k_adr | k_din;
  wire page_op = k_din | k_dout;
  wire in_x = (st == S_XFER);
  wire low = ph < PW'(T_LO);
  wire byte_end = in_x && ph == PW'(T_LO + T_HI - 1);
  wire smp = in_x && is_rd && ph == PW'(T_LO - 1);

  wire       op_wr = h_wr && h_addr == A_OPER;
  wire [5:0] trig = h_wdata[5:0];
  wire       one_hot = trig != 6'd0 && (trig & (trig - 6'd1)) == 6'd0;

  always_comb begin
    if (page_op) last = sp ? CW'(SPARE_BYTES - 1) : CW'(PAGE - 1);
    else if (k_id) last = CW'(ID_BYTES - 1);
    else last = '0;
    soff = sp ? cnt : cnt - CW'(MAIN_BYTES);
    if (page_op && (sp || cnt >= CW'(MAIN_BYTES)))
      baddr = AW'(SPARE_BASE) + AW'(area) * AW'(SPARE_BYTES) + AW'(soff);
    else
      baddr = AW'(area) * AW'(MAIN_BYTES) + AW'(cnt);
  end

  assign nf_we_n = !(in_x && is_wr && low);
  assign nf_re_n = !(in_x && is_rd && low);
  assign nf_cle  = in_x && k_cmd;
  assign nf_ale  = in_x && k_adr;
  assign nf_doe  = in_x && is_wr;
  assign nf_dout = k_cmd ? cmd_r : k_adr ? addr_r[7:0] : mem[baddr];
  assign nf_ce_n = !(st != S_IDLE || cfg[7]);
  assign irq     = done && !cfg[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; done <= 1'b0; sp <= 1'b0;
      cfg <= 8'h10; cmd_r <= '0; addr_r <= '0; bsel <= '0; area <= '0;
      cnt <= '0; ph <= '0; rb_m <= 1'b0; rb_q <= 1'b0;
    end else begin
      rb_m <= nf_rb;
      rb_q <= rb_m;
      if (h_wr && h_addr == A_CFG)  cfg    <= h_wdata[7:0];
      if (h_wr && h_addr == A_BSEL) bsel   <= h_wdata[1:0];
      if (h_wr && h_addr == A_CMD)  cmd_r  <= h_wdata[7:0];
      if (h_wr && h_addr == A_ADDR) addr_r <= h_wdata;
      case (st)
        S_IDLE:
          if (op_wr && one_hot) begin
            op <= trig; done <= 1'b0; area <= bsel; sp <= cfg[2];
            cnt <= '0; ph <= '0; st <= S_XFER;
          end else if (op_wr && trig == 6'd0 && !h_wdata[15]) begin
            done <= 1'b0;
          end
        S_XFER:
          if (byte_end) begin
            ph <= '0;
            if (cnt == last) st <= S_GAP;
            else cnt <= cnt + 1'b1;
          end else ph <= ph + 1'b1;
        S_GAP:
          if (ph == PW'(RB_GAP - 1)) begin ph <= '0; st <= S_WAITRB; end
          else ph <= ph + 1'b1;
        default:
          if (rb_q) begin done <= 1'b1; op <= '0; st <= S_IDLE; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (smp) mem[baddr] <= nf_din;
    else if (h_wr && h_addr < 12'(BUF_BYTES)) mem[h_addr[AW-1:0]] <= h_wdata[7:0];
  end

  always_comb begin
    case (h_addr)
      A_OPER:  h_rdata = {done, 9'b0, op};
      A_CFG:   h_rdata = {8'h00, cfg};
      A_BSEL:  h_rdata = {14'b0, bsel};
      A_CMD:   h_rdata = {8'h00, cmd_r};
      A_ADDR:  h_rdata = addr_r;
      default: h_rdata = (h_addr < 12'(BUF_BYTES)) ? {8'h00, mem[h_addr[AW-1:0]]} : 16'h0000;
    endcase
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int T_LO = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        nf_cle,
  input logic        nf_ale,
  input logic        nf_we_n,
  input logic        nf_re_n,
  input logic        nf_ce_n,
  input logic        done,
  input logic        rb_q,
  input logic        h_wr,
  input logic [11:0] h_addr,
  input logic [15:0] h_wdata,
  input logic [5:0]  op
);
  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  generate
    if (T_LO > 1) begin : g_width
      p_we_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_we_n) |=> !nf_we_n);
      p_re_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_re_n) |=> !nf_re_n);
    end
  endgenerate

  p_ce_on_bus_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_cle || nf_ale || !nf_we_n || !nf_re_n) |-> !nf_ce_n);

  p_done_after_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rb_q));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(h_wr && h_addr == 12'hE00 && !h_wdata[15]));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 6'd0 && h_wr && h_addr == 12'hE00) |=> (op == $past(op) || op == 6'd0));
endmodule

bind nand_seq nand_seq_chk #(.T_LO(T_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
  .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n), .done(done), .rb_q(rb_q), .h_wr(h_wr),
  .h_addr(h_addr), .h_wdata(h_wdata), .op(op)
);

// File: tb/test_nand_seq.sv
module test_nand_seq;
  localparam int T_LO = 2;
  localparam logic [11:0] A_OPER = 12'hE00, A_CFG = 12'hE02, A_BSEL = 12'hE04,
                          A_CMD = 12'hE06, A_ADDR = 12'hE08;

  logic clk = 0, rst_n = 0, h_wr = 0, nf_rb = 1;
  logic [11:0] h_addr = 0;
  logic [15:0] h_wdata = 0, h_rdata;
  logic irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_doe;
  logic [7:0] nf_dout, nf_din;

  int tests = 0, fails = 0, finished = 0;
  int wlog_n = 0, rd_idx = 0, busy_len = 0, bcnt = 0, busy_req = 0;
  int wl = 0, rl = 0, we_bad = 0, re_bad = 0, we_pulses = 0, re_pulses = 0;
  logic [9:0] wlog [0:1023];

  always #5 clk = ~clk;

  nand_seq i_nand_seq (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .irq(irq), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dout(nf_dout), .nf_doe(nf_doe),
    .nf_din(nf_din), .nf_rb(nf_rb)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] fill(input int i);
    return 8'((i * 7 + 3) ^ 8'h5a);
  endfunction

  assign nf_din = pat(rd_idx);

  always @(posedge nf_we_n) if (rst_n) begin
    if (wlog_n < 1024) wlog[wlog_n] = {nf_cle, nf_ale, nf_dout};
    wlog_n++;
    busy_req = 1;
  end

  always @(posedge nf_re_n) if (rst_n) rd_idx++;

  always @(posedge clk) begin
    if (busy_req != 0) begin busy_req = 0; bcnt = busy_len; end
    if (bcnt > 0) begin bcnt--; nf_rb <= 0; end
    else nf_rb <= 1;
  end

  always @(negedge clk) begin
    if (!nf_we_n) wl++;
    else if (wl != 0) begin if (wl != T_LO) we_bad++; we_pulses++; wl = 0; end
    if (!nf_re_n) rl++;
    else if (rl != 0) begin if (rl != T_LO) re_bad++; re_pulses++; rl = 0; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); h_addr = a; #1 d = h_rdata;
  endtask

  task automatic wait_done();
    logic [15:0] v;
    for (int k = 0; k < 20000; k++) begin
      rd(A_OPER, v);
      if (v[15]) return;
    end
    check(0, "R9 done timeout", 0, 1);
  endtask

  task automatic run_op(input logic [15:0] code);
    wr(A_OPER, code);
    wait_done();
  endtask

  initial begin
    #(10 * 190000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n0, s, bad, t0;
    void'($urandom(1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_OPER, v); check(v == 16'h0000, "R1 oper", v, 0);
    rd(A_CFG, v);  check(v == 16'h0010, "R1 cfg", v, 16'h10);
    check({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq} == 6'b111000, "R1 pins",
          {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, 6'b111000);

    // R2 / R3 random command and address phases
    for (int k = 0; k < 6; k++) begin
      logic [7:0] c;
      logic [15:0] a;
      c = 8'($urandom);
      a = 16'($urandom);
      busy_len = int'($urandom % 20);
      wr(A_CMD, {8'h00, c}); n0 = wlog_n; run_op(16'h0001);
      check(wlog_n == n0 + 1, "R2 pulse count", wlog_n - n0, 1);
      check(wlog[n0] == {2'b10, c}, "R2 cmd byte", wlog[n0], {2'b10, c});
      wr(A_ADDR, a); n0 = wlog_n; run_op(16'h0002);
      check(wlog_n == n0 + 1, "R3 pulse count", wlog_n - n0, 1);
      check(wlog[n0] == {2'b01, a[7:0]}, "R3 addr byte", wlog[n0], {2'b01, a[7:0]});
    end

    // R9 done waits for ready, stays set; R10 irq
    busy_len = 40;
    wr(A_CMD, 16'h0060);
    t0 = int'($time);
    wr(A_OPER, 16'h0001);
    repeat (15) @(negedge clk);
    rd(A_OPER, v); check(v[15] == 1'b0, "R9 done while busy", v[15], 0);
    wait_done();
    check((int'($time) - t0) / 10 >= 40, "R9 done after ready", (int'($time) - t0) / 10, 40);
    repeat (20) @(negedge clk);
    rd(A_OPER, v); check(v[15] == 1'b1, "R9 sticky", v[15], 1);
    check(irq == 1'b0, "R10 masked", irq, 0);
    wr(A_CFG, 16'h0000); #1;
    check(irq == 1'b1, "R10 unmasked", irq, 1);
    wr(A_OPER, 16'h0000);
    rd(A_OPER, v); check(v[15] == 1'b0, "R9 clear", v[15], 0);
    check(irq == 1'b0, "R10 after clear", irq, 0);
    busy_len = 0;

    // R4 data input of area 2, with R11 write during busy
    for (int i = 0; i < 512; i++) wr(12'(12'h400 + i), {8'h00, fill(i)});
    for (int j = 0; j < 16; j++) wr(12'(12'h820 + j), {8'h00, fill(512 + j)});
    wr(A_BSEL, 16'h0002);
    n0 = wlog_n;
    wr(A_OPER, 16'h0004);
    repeat (100) @(negedge clk);
    wr(A_OPER, 16'h0001);
    wait_done();
    check(wlog_n == n0 + 528, "R4 byte count", wlog_n - n0, 528);
    bad = 0;
    for (int i = 0; i < 528; i++) if (wlog[n0 + i] != {2'b00, fill(i)}) bad++;
    check(bad == 0, "R4 bytes and R11 ignored write", bad, 0);

    // R5 page output into area 1
    wr(A_BSEL, 16'h0001);
    s = rd_idx;
    run_op(16'h0008);
    check(rd_idx == s + 528, "R5 read count", rd_idx - s, 528);
    bad = 0;
    for (int i = 0; i < 512; i++) begin rd(12'(12'h200 + i), v); if (v[7:0] != pat(s + i)) bad++; end
    for (int j = 0; j < 16; j++) begin rd(12'(12'h810 + j), v); if (v[7:0] != pat(s + 512 + j)) bad++; end
    check(bad == 0, "R5 buffer contents", bad, 0);
    rd(12'h400, v); check(v[7:0] == fill(0), "R5 other area kept", v, fill(0));

    // R6 spare-only, both directions
    wr(A_CFG, 16'h0004);
    wr(A_BSEL, 16'h0002);
    n0 = wlog_n; run_op(16'h0004);
    check(wlog_n == n0 + 16, "R6 input count", wlog_n - n0, 16);
    bad = 0;
    for (int j = 0; j < 16; j++) if (wlog[n0 + j] != {2'b00, fill(512 + j)}) bad++;
    check(bad == 0, "R6 input bytes", bad, 0);
    wr(12'h600, 16'h00EE);
    wr(A_BSEL, 16'h0003);
    s = rd_idx; run_op(16'h0008);
    check(rd_idx == s + 16, "R6 output count", rd_idx - s, 16);
    bad = 0;
    for (int j = 0; j < 16; j++) begin rd(12'(12'h830 + j), v); if (v[7:0] != pat(s + j)) bad++; end
    check(bad == 0, "R6 output bytes", bad, 0);
    rd(12'h600, v); check(v[7:0] == 8'hEE, "R6 main untouched", v, 8'hEE);
    wr(A_CFG, 16'h0000);

    // R7 ID read into area 0
    wr(12'h005, 16'h0033);
    wr(A_BSEL, 16'h0000);
    s = rd_idx; run_op(16'h0010);
    bad = 0;
    for (int i = 0; i < 5; i++) begin rd(12'(i), v); if (v[7:0] != pat(s + i)) bad++; end
    check(bad == 0, "R7 id bytes", bad, 0);
    rd(12'h005, v); check(v[7:0] == 8'h33, "R7 byte 5 kept", v, 8'h33);

    // R8 status read into area 3
    wr(A_BSEL, 16'h0003);
    s = rd_idx; run_op(16'h0020);
    check(rd_idx == s + 1, "R8 one read", rd_idx - s, 1);
    rd(12'h600, v); check(v[7:0] == pat(s), "R8 status byte", v, pat(s));

    // R11 multi-bit write ignored
    n0 = wlog_n; s = rd_idx;
    wr(A_OPER, 16'h0003);
    repeat (50) @(negedge clk);
    rd(A_OPER, v); check(v == 16'h8000, "R11 done unchanged", v, 16'h8000);
    check(wlog_n == n0 && rd_idx == s, "R11 no bus activity", wlog_n - n0 + rd_idx - s, 0);

    // R12 strobe widths
    check(we_bad == 0 && we_pulses > 0, "R12 we width", we_bad, 0);
    check(re_bad == 0 && re_pulses > 0, "R12 re width", re_bad, 0);

    // R13 forced chip enable
    wr(A_CFG, 16'h0080); #1;
    check(nf_ce_n == 1'b0, "R13 forced", nf_ce_n, 0);
    wr(A_CFG, 16'h0000); #1;
    check(nf_ce_n == 1'b1, "R13 released", nf_ce_n, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule